// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the integer execute stage of a 32-bit processor core. Each cycle with a valid operation it reads a first operand from a 32-entry register file. It takes a second operand either from the register file or from a sign-extended 13-bit immediate, computes a 32-bit result and writes that result back to the register file. It can also update four condition flags: negative (N), zero (Z), overflow (V) and carry/borrow (C).

The operations are add and subtract with optional carry chaining, six bitwise operations, three shifts, an upper-immediate load, and tagged add and subtract. Tagged arithmetic treats the two low bits of each operand as a type tag. An optional trapping form of it suppresses all architectural updates and raises a trap pulse instead. Register 0 always reads as zero.

The result of each operation is also shown on a registered output, so a consumer can observe it one clock after issue. The asynchronous reset input is released into the block through a two-stage synchroniser.

Top module: `int_exec_unit`

## Requirements
- R1: When `use_imm` is 1, the second operand is `imm13` sign-extended to 32 bits; when it is 0, the second operand is register `rs2_addr`.
- R2: `op_sel` encodes: 0 add, 1 add with C, 2 subtract, 3 subtract with C (borrow), 4 AND, 5 AND-NOT (a & ~b), 6 OR, 7 OR-NOT (a | ~b), 8 XOR, 9 XNOR, 10 shift left logical, 11 shift right logical, 12 shift right arithmetic, 13 upper load, 14 tagged add, 15 tagged subtract. The carry-using forms add C to the sum, or subtract C from the difference, as 0 or 1.
- R3: In the flag-setting arithmetic forms, N is result bit 31, Z is set when the result is zero, V is set on signed overflow, and C is the carry out for add or the borrow for subtract. `cc_o` bit order is {N, Z, V, C} from bit 3 down to bit 0.
- R4: The flag-setting bitwise operations set N and Z from the result and clear V and C.
- R5: Shifts use the low 5 bits of the second operand as the shift amount. Logical shifts fill with zeros and the arithmetic right shift fills with bit 31. Shifts and the upper load never change the flags, even when `set_cc` is 1.
- R6: The upper load writes `imm22` to bits 31:10 of the result and zeros to bits 9:0.
- R7: When `set_cc` is 0, the flags keep their value.
- R8: Register 0 reads as zero and writes to it are dropped. Flags still update when register 0 is the destination.
- R9: Tagged add and subtract compute V as signed overflow ORed with "either operand has nonzero bits 1:0"; C is computed as for plain add or subtract.
- R10: A tagged operation with `trap_en` set and V as defined in R9 pulses `trap_o` for one cycle, and modifies neither the destination register nor the flags. `trap_en` has no effect on other operations.
- R11: After reset, `result_o`, `cc_o`, `trap_o` and every register are zero.
- R12: `result_o` and `cc_o` show the outcome of an operation issued at a rising edge from that edge onward, and the written register is readable by the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_sel | input | 4 | Operation code (see R2) |
| set_cc | input | 1 | Request flag update |
| trap_en | input | 1 | Trapping form of tagged operations |
| rd_addr | input | 5 | Destination register |
| rs1_addr | input | 5 | First source register |
| rs2_addr | input | 5 | Second source register |
| use_imm | input | 1 | Select immediate as second operand |
| imm13 | input | 13 | Signed immediate |
| imm22 | input | 22 | Upper-load constant |
| result_o | output | 32 | Registered result of the last operation |
| cc_o | output | 4 | Flags {N, Z, V, C} |
| trap_o | output | 1 | Tag-overflow trap pulse |

## Verification
The bench attacks the flag edges first: a signed add that wraps to 0x80000000, an add that carries out to zero, and subtracts that borrow or overflow. A design with carry and borrow mixed up, or with the wrong overflow terms, shows wrong C or V here. Carry-chained add and subtract run with C set, which catches a design that inverts the incoming carry on subtract. Shifts by a register whose value exceeds 31, and an arithmetic shift of a negative number, expose masking and fill errors; a shift or upper load issued with the flag request set exposes flags that leak through. Tagged operands with tag bits set, and a trapping tagged add, show whether V includes the tag and whether a trap still writes the register or the flags.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int IMMW  = 13;
  localparam int UPW   = 22;
  localparam int SHW   = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_ANDN = 4'd5,
    OP_OR   = 4'd6,
    OP_ORN  = 4'd7,
    OP_XOR  = 4'd8,
    OP_XNOR = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_UPR  = 4'd13,
    OP_TADD = 4'd14,
    OP_TSUB = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/alu_regfile.sv
module alu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b,
  input  logic            wen,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic load_en;
      assign load_en = wen && (waddr == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       regs[g] <= '0;
        else if (load_en) regs[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int XLEN = 32,
  parameter int IMMW = 13
) (
  input  logic            use_imm,
  input  logic [IMMW-1:0] imm,
  input  logic [XLEN-1:0] reg_val,
  output logic [XLEN-1:0] opb
);
  logic [XLEN-1:0] imm_ext;
  assign imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign opb     = use_imm ? imm_ext : reg_val;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  input  logic            use_c,
  input  logic            c_flag,
  output logic [XLEN-1:0] sum,
  output logic            carry,
  output logic            ovf
);
  logic [XLEN-1:0] b_eff;
  logic            cin;
  logic [XLEN:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    if (sub) cin = use_c ? ~c_flag : 1'b1;
    else     cin = use_c ?  c_flag : 1'b0;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, cin};
    sum   = wide[XLEN-1:0];
    carry = sub ? ~wide[XLEN] : wide[XLEN];
    ovf   = (a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int UPW  = 22,
  parameter int SHW  = $clog2(XLEN)
) (
  input  alu_op_e         op,
  input  logic            set_cc,
  input  logic            trap_en,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [UPW-1:0]  imm_up,
  input  logic            c_flag,
  output logic [XLEN-1:0] res,
  output cc_t             cc_next,
  output logic            cc_update,
  output logic            tag_trap
);
  logic            is_sub, is_usec, is_tag, is_arith, is_noflag;
  logic [XLEN-1:0] sum;
  logic            carry, ovf, tag_nz, v_arith;
  logic [SHW-1:0]  shamt;

  always_comb begin
    is_sub    = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_TSUB);
    is_usec   = (op == OP_ADDC) || (op == OP_SUBC);
    is_tag    = (op == OP_TADD) || (op == OP_TSUB);
    is_arith  = is_tag || (op == OP_ADD) || (op == OP_ADDC) ||
                (op == OP_SUB) || (op == OP_SUBC);
    is_noflag = (op == OP_SLL) || (op == OP_SRL) ||
                (op == OP_SRA) || (op == OP_UPR);
  end

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a      (opa),
    .b      (opb),
    .sub    (is_sub),
    .use_c  (is_usec),
    .c_flag (c_flag),
    .sum    (sum),
    .carry  (carry),
    .ovf    (ovf)
  );

  assign shamt   = opb[SHW-1:0];
  assign tag_nz  = (|opa[1:0]) || (|opb[1:0]);
  assign v_arith = ovf || (is_tag && tag_nz);

  always_comb begin
    unique case (op)
      OP_AND:  res = opa & opb;
      OP_ANDN: res = opa & ~opb;
      OP_OR:   res = opa | opb;
      OP_ORN:  res = opa | ~opb;
      OP_XOR:  res = opa ^ opb;
      OP_XNOR: res = ~(opa ^ opb);
      OP_SLL:  res = opa << shamt;
      OP_SRL:  res = opa >> shamt;
      OP_SRA:  res = $unsigned($signed(opa) >>> shamt);
      OP_UPR:  res = {imm_up, {(XLEN-UPW){1'b0}}};
      default: res = sum;
    endcase
  end

  always_comb begin
    cc_next.n = res[XLEN-1];
    cc_next.z = (res == '0);
    cc_next.v = is_arith ? v_arith : 1'b0;
    cc_next.c = is_arith ? carry   : 1'b0;
    cc_update = set_cc && !is_noflag;
    tag_trap  = is_tag && trap_en && v_arith;
  end

  always_comb begin
    if (op == OP_UPR) begin
      assert_upper_low_clear_R6: assert (res[XLEN-UPW-1:0] == '0);
    end
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_sel,
  input  logic        set_cc,
  input  logic        trap_en,
  input  logic [4:0]  rd_addr,
  input  logic [4:0]  rs1_addr,
  input  logic [4:0]  rs2_addr,
  input  logic        use_imm,
  input  logic [12:0] imm13,
  input  logic [21:0] imm22,
  output logic [31:0] result_o,
  output logic [3:0]  cc_o,
  output logic        trap_o
);
  localparam int AW = $clog2(NREG);

  logic            rst_q1, rst_n_s;
  logic [XLEN-1:0] opa, rs2_val, opb, res;
  cc_t             cc_q, cc_d, cc_calc;
  logic            cc_update, tag_trap;
  logic            wen, cc_en, res_en, trap_d;
  logic [XLEN-1:0] res_q, res_d;
  logic            trap_q;
  alu_op_e         op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_n_s <= rst_q1;
    end
  end

  assign op = alu_op_e'(op_sel);

  alu_regfile #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .raddr_a (rs1_addr),
    .raddr_b (rs2_addr),
    .rdata_a (opa),
    .rdata_b (rs2_val),
    .wen     (wen),
    .waddr   (rd_addr),
    .wdata   (res)
  );

  alu_operand_sel #(.XLEN(XLEN), .IMMW(IMMW)) u_opsel (
    .use_imm (use_imm),
    .imm     (imm13),
    .reg_val (rs2_val),
    .opb     (opb)
  );

  alu_core #(.XLEN(XLEN), .UPW(UPW), .SHW(SHW)) u_core (
    .op        (op),
    .set_cc    (set_cc),
    .trap_en   (trap_en),
    .opa       (opa),
    .opb       (opb),
    .imm_up    (imm22),
    .c_flag    (cc_q.c),
    .res       (res),
    .cc_next   (cc_calc),
    .cc_update (cc_update),
    .tag_trap  (tag_trap)
  );

  // next-state logic
  always_comb begin
    wen    = op_valid && !tag_trap;
    cc_en  = op_valid && cc_update && !tag_trap;
    res_en = op_valid;
    trap_d = op_valid && tag_trap;
    cc_d   = cc_en  ? cc_calc : cc_q;
    res_d  = res_en ? res     : res_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cc_q   <= '0;
      res_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      cc_q   <= cc_d;
      res_q  <= res_d;
      trap_q <= trap_d;
    end
  end

  assign result_o = res_q;
  assign cc_o     = cc_q;
  assign trap_o   = trap_q;

  assert_reg0_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && rs1_addr == '0) |-> (opa == '0));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(op_valid && set_cc) |=> $stable(cc_o));

  assert_shift_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && (op == OP_SLL || op == OP_SRL || op == OP_SRA || op == OP_UPR)) |=> $stable(cc_o));

  assert_trap_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    trap_o |-> $stable(cc_o));

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && set_cc && !tag_trap && (op == OP_ADD || op == OP_SUB))
      |=> (cc_o[2] == (result_o == '0)));
endmodule

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic        set_cc, trap_en, use_imm;
  logic [4:0]  rd_addr, rs1_addr, rs2_addr;
  logic [12:0] imm13;
  logic [21:0] imm22;
  logic [31:0] result_o;
  logic [3:0]  cc_o;
  logic        trap_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .set_cc(set_cc), .trap_en(trap_en), .rd_addr(rd_addr),
    .rs1_addr(rs1_addr), .rs2_addr(rs2_addr), .use_imm(use_imm),
    .imm13(imm13), .imm22(imm22), .result_o(result_o), .cc_o(cc_o),
    .trap_o(trap_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic exec(input logic [3:0] op, input logic sc, input logic tr,
                      input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2,
                      input logic ui, input logic [12:0] imm, input logic [21:0] up);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; set_cc = sc; trap_en = tr;
    rd_addr = rd; rs1_addr = rs1; rs2_addr = rs2;
    use_imm = ui; imm13 = imm; imm22 = up;
    @(negedge clk);
    op_valid = 1'b0; set_cc = 1'b0; trap_en = 1'b0;
  endtask

  task automatic set_reg(input logic [4:0] rd, input logic [31:0] val);
    exec(4'd13, 1'b0, 1'b0, rd, 5'd0, 5'd0, 1'b0, 13'd0, val[31:10]);
    exec(4'd6,  1'b0, 1'b0, rd, rd,   5'd0, 1'b1, {3'b000, val[9:0]}, 22'd0);
  endtask

  task automatic read_reg(input logic [4:0] rs, output logic [31:0] val);
    exec(4'd6, 1'b0, 1'b0, 5'd0, rs, 5'd0, 1'b1, 13'd0, 22'd0);
    val = result_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R11 result", result_o, 32'h0);
    chk("R11 flags", {28'h0, cc_o}, 32'h0);
    chk("R11 trap", {31'h0, trap_o}, 32'h0);
    read_reg(5'd17, v);
    chk("R11 register", v, 32'h0);
  endtask

  task automatic t_immediate;
    logic [31:0] v;
    exec(4'd0, 1'b0, 1'b0, 5'd1, 5'd0, 5'd0, 1'b1, 13'h1FFF, 22'd0);
    chk("R1 sign-extended imm", result_o, 32'hFFFF_FFFF);
    read_reg(5'd1, v);
    chk("R12 writeback visible", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_upper;
    exec(4'd13, 1'b0, 1'b0, 5'd2, 5'd0, 5'd0, 1'b0, 13'd0, 22'h3C0554);
    chk("R6 upper load", result_o, 32'hF015_5000);
    exec(4'd0, 1'b0, 1'b0, 5'd2, 5'd2, 5'd0, 1'b1, 13'h2A0, 22'd0);
    chk("R6 upper plus offset", result_o, 32'hF015_52A0);
  endtask

  task automatic t_logic;
    exec(4'd0, 1'b0, 1'b0, 5'd3, 5'd0, 5'd0, 1'b1, 13'h055, 22'd0);
    exec(4'd4, 1'b0, 1'b0, 5'd5, 5'd3, 5'd0, 1'b1, 13'h049, 22'd0);
    chk("R4 AND", result_o, 32'h0000_0041);
    exec(4'd5, 1'b0, 1'b0, 5'd5, 5'd3, 5'd0, 1'b1, 13'h049, 22'd0);
    chk("R4 AND-NOT", result_o, 32'h0000_0014);
    exec(4'd6, 1'b0, 1'b0, 5'd5, 5'd3, 5'd0, 1'b1, 13'h049, 22'd0);
    chk("R4 OR", result_o, 32'h0000_005D);
    exec(4'd7, 1'b0, 1'b0, 5'd5, 5'd3, 5'd0, 1'b1, 13'h049, 22'd0);
    chk("R4 OR-NOT", result_o, 32'hFFFF_FFF7);
    exec(4'd8, 1'b0, 1'b0, 5'd5, 5'd3, 5'd0, 1'b1, 13'h049, 22'd0);
    chk("R4 XOR", result_o, 32'h0000_001C);
    exec(4'd9, 1'b1, 1'b0, 5'd5, 5'd3, 5'd0, 1'b1, 13'h049, 22'd0);
    chk("R4 XNOR", result_o, 32'hFFFF_FFE3);
    chk("R4 XNOR flags", {28'h0, cc_o}, 32'h8);
  endtask

  task automatic t_addsub;
    set_reg(5'd4, 32'h7FFF_FFFF);
    exec(4'd0, 1'b1, 1'b0, 5'd6, 5'd4, 5'd0, 1'b1, 13'd1, 22'd0);
    chk("R3 signed overflow result", result_o, 32'h8000_0000);
    chk("R3 overflow flags", {28'h0, cc_o}, 32'hA);
    exec(4'd0, 1'b1, 1'b0, 5'd7, 5'd1, 5'd0, 1'b1, 13'd1, 22'd0);
    chk("R3 carry-out result", result_o, 32'h0);
    chk("R3 carry/zero flags", {28'h0, cc_o}, 32'h5);
    exec(4'd1, 1'b0, 1'b0, 5'd8, 5'd0, 5'd0, 1'b1, 13'd0, 22'd0);
    chk("R2 add with carry", result_o, 32'h1);
    chk("R7 flags kept", {28'h0, cc_o}, 32'h5);
    exec(4'd2, 1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 13'd1, 22'd0);
    chk("R3 borrow result", result_o, 32'hFFFF_FFFF);
    chk("R3 borrow flags", {28'h0, cc_o}, 32'h9);
    exec(4'd3, 1'b0, 1'b0, 5'd8, 5'd3, 5'd0, 1'b1, 13'd5, 22'd0);
    chk("R2 subtract with borrow", result_o, 32'h4F);
    chk("R7 flags kept after SUBC", {28'h0, cc_o}, 32'h9);
    exec(4'd2, 1'b1, 1'b0, 5'd8, 5'd6, 5'd0, 1'b1, 13'd1, 22'd0);
    chk("R3 subtract overflow result", result_o, 32'h7FFF_FFFF);
    chk("R3 subtract overflow flags", {28'h0, cc_o}, 32'h2);
  endtask

  task automatic t_shift;
    exec(4'd12, 1'b1, 1'b0, 5'd9, 5'd6, 5'd0, 1'b1, 13'd4, 22'd0);
    chk("R5 arithmetic right", result_o, 32'hF800_0000);
    chk("R5 flags untouched", {28'h0, cc_o}, 32'h2);
    exec(4'd11, 1'b0, 1'b0, 5'd9, 5'd6, 5'd0, 1'b1, 13'd4, 22'd0);
    chk("R5 logical right", result_o, 32'h0800_0000);
    exec(4'd0, 1'b0, 1'b0, 5'd10, 5'd0, 5'd0, 1'b1, 13'd33, 22'd0);
    exec(4'd10, 1'b1, 1'b0, 5'd9, 5'd3, 5'd10, 1'b0, 13'd0, 22'd0);
    chk("R5 shift amount low 5 bits", result_o, 32'h0000_00AA);
    exec(4'd10, 1'b0, 1'b0, 5'd9, 5'd3, 5'd0, 1'b1, 13'd31, 22'd0);
    chk("R5 shift by 31", result_o, 32'h8000_0000);
    exec(4'd13, 1'b1, 1'b0, 5'd9, 5'd0, 5'd0, 1'b0, 13'd0, 22'h0);
    chk("R5 upper load keeps flags", {28'h0, cc_o}, 32'h2);
  endtask

  task automatic t_zero_reg;
    logic [31:0] v;
    exec(4'd0, 1'b1, 1'b0, 5'd0, 5'd3, 5'd0, 1'b1, 13'd1, 22'd0);
    chk("R8 flags update for r0 dest", {28'h0, cc_o}, 32'h0);
    read_reg(5'd0, v);
    chk("R8 r0 stays zero", v, 32'h0);
  endtask

  task automatic t_tagged;
    exec(4'd0, 1'b0, 1'b0, 5'd11, 5'd0, 5'd0, 1'b1, 13'd4, 22'd0);
    exec(4'd0, 1'b0, 1'b0, 5'd12, 5'd0, 5'd0, 1'b1, 13'd5, 22'd0);
    exec(4'd14, 1'b1, 1'b0, 5'd13, 5'd11, 5'd0, 1'b1, 13'd8, 22'd0);
    chk("R9 clean tags result", result_o, 32'hC);
    chk("R9 clean tags flags", {28'h0, cc_o}, 32'h0);
    exec(4'd14, 1'b1, 1'b0, 5'd13, 5'd12, 5'd0, 1'b1, 13'd8, 22'd0);
    chk("R9 tag bits set V", {28'h0, cc_o}, 32'h2);
    chk("R10 no trap without trap_en", {31'h0, trap_o}, 32'h0);
    set_reg(5'd14, 32'h7FFF_FFFC);
    exec(4'd14, 1'b1, 1'b0, 5'd13, 5'd14, 5'd0, 1'b1, 13'd4, 22'd0);
    chk("R9 tagged overflow flags", {28'h0, cc_o}, 32'hA);
    exec(4'd15, 1'b1, 1'b0, 5'd13, 5'd11, 5'd0, 1'b1, 13'd4, 22'd0);
    chk("R9 tagged subtract flags", {28'h0, cc_o}, 32'h4);
  endtask

  task automatic t_trap;
    logic [31:0] v;
    exec(4'd14, 1'b1, 1'b1, 5'd15, 5'd12, 5'd0, 1'b1, 13'd8, 22'd0);
    chk("R10 trap pulse", {31'h0, trap_o}, 32'h1);
    chk("R10 flags kept on trap", {28'h0, cc_o}, 32'h4);
    read_reg(5'd15, v);
    chk("R10 destination kept on trap", v, 32'h0);
    chk("R10 trap lasts one cycle", {31'h0, trap_o}, 32'h0);
    exec(4'd14, 1'b1, 1'b1, 5'd15, 5'd11, 5'd0, 1'b1, 13'd8, 22'd0);
    chk("R10 clean trapping op no trap", {31'h0, trap_o}, 32'h0);
    chk("R10 clean trapping op flags", {28'h0, cc_o}, 32'h0);
    read_reg(5'd15, v);
    chk("R10 clean trapping op writes", v, 32'hC);
    exec(4'd6, 1'b0, 1'b1, 5'd16, 5'd12, 5'd0, 1'b1, 13'd2, 22'd0);
    chk("R10 trap_en ignored on OR", {31'h0, trap_o}, 32'h0);
    chk("R10 trap_en ignored OR result", result_o, 32'h7);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 4'd0; set_cc = 1'b0; trap_en = 1'b0;
    rd_addr = 5'd0; rs1_addr = 5'd0; rs2_addr = 5'd0; use_imm = 1'b0;
    imm13 = 13'd0; imm22 = 22'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_immediate;
    t_upper;
    t_logic;
    t_addsub;
    t_shift;
    t_zero_reg;
    t_tagged;
    t_trap;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule